// File: doc/BRIEF.md
# Watchpoint Input Sampling Conditioner

This block sits between a set of watchpoint comparators and the trace trigger logic. Each comparator match line comes in unsynchronised to the trace sampling rhythm. The conditioner turns each line into a clean signal that the trigger logic can consume. A `sample_strobe` input marks every sampling point. A `pre_sample` input is raised one cycle before each strobe and ends any held state.

Each input has a mode bit in a 32-bit control word. In pulse mode, an input that is active at a sampling point produces a one-cycle output pulse. In hold mode, an active input is latched, and the output stays high until `pre_sample` clears it, which is one cycle ahead of the next sampling point.

A second, read-only word reports how many inputs exist and whether the control word is fitted. When the control word is left out by parameter, every input works in pulse mode and the control word reads as zero. Registers are reached through a one-cycle write strobe and a combinational read port.

Top module: `wp_sample_cond`

## Requirements
- R1: Control word bit i selects the mode of input i (`wp_in[i]` / `wp_out[i]`), 0 = pulse mode, 1 = hold mode; the register is addressed with `reg_sel` = 0.
- R2: In pulse mode, `sample_strobe` high with `wp_in[i]` high on a clock edge drives `wp_out[i]` high for the one following cycle only, unless the input is sampled active again.
- R3: In hold mode, a sampled active input sets `wp_out[i]` from the next cycle and keeps it high until the edge on which `pre_sample` is high; `wp_out[i]` is low in the cycle after that edge.
- R4: When `pre_sample` and a sampling point with the input active fall on the same edge in hold mode, `wp_out[i]` stays high without a gap.
- R5: Control word bits [31:8] always read as zero and ignore writes.
- R6: Mode bits at and above NUM_INPUTS read as zero and ignore writes.
- R7: With `reg_sel` = 1 the read data is the capability word: bits [3:0] = NUM_INPUTS, bit 4 = 1 when the control word is fitted, all other bits zero; writes to it are ignored.
- R8: With HAS_CTRL = 0 the control word reads as zero and every input behaves in pulse mode whatever is written.
- R9: Synchronous active-low reset clears the control word (all inputs in pulse mode) and all outputs.
- R10: A control write changes behaviour from the next sampling point on and does not end an output already being held.
- R11: Without `sample_strobe`, an input change never raises an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_strobe | input | 1 | Marks a sampling point |
| pre_sample | input | 1 | High one cycle before each sampling point; clears held outputs |
| wp_in | input | NUM_INPUTS | Comparator match lines |
| wp_out | output | NUM_INPUTS | Conditioned match outputs |
| reg_sel | input | 1 | Register select: 0 control word, 1 capability word |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the selected register |

## Verification
The bench targets the boundary between a held output and the next sampling point. This includes `pre_sample` landing on the same edge as a qualifying strobe: a set-versus-clear priority error would show there as a one-cycle gap. The bench also clears a mode bit while its output is held; a design that applied the write at once would drop that output early.

The bench writes all ones to a control word with six inputs. A design that did not mask the reserved and missing bits would read back more than 0x3F. A second instance without the control word receives the same writes; it must keep pulsing, or it has leaked a mode bit. Pulse mode is also driven with inputs that stay high between strobes, which exposes a design that follows its input level.

// File: rtl/wp_pkg.sv
// Package: shared constants for the watchpoint sampling conditioner.
// Assumes a 32-bit register data path and at most eight inputs.
package wp_pkg;
    localparam int REG_W        = 32;
    localparam int MAX_INPUTS   = 8;
    localparam int CAP_CNT_W    = 4;
    localparam int CAP_PRES_BIT = 4;
    localparam logic SEL_CTRL   = 1'b0;
    localparam logic SEL_CAP    = 1'b1;

    // Builds the read-only capability word from the build parameters.
    function automatic logic [REG_W-1:0] cap_word(input int n_inputs, input bit has_ctrl);
        logic [REG_W-1:0] w;
        w = '0;
        w[CAP_CNT_W-1:0] = CAP_CNT_W'(n_inputs);
        w[CAP_PRES_BIT]  = has_ctrl;
        return w;
    endfunction
endpackage

// File: rtl/wp_ctrl_regs.sv
// Module: control and capability registers.
// Holds one mode bit per fitted input and serves the combinational read port.
// Assumes NUM_INPUTS is between 1 and 8. With HAS_CTRL = 0 no storage is
// built, the mode bits stay at zero and the control word reads as zero.
module wp_ctrl_regs
    import wp_pkg::*;
#(
    parameter int NUM_INPUTS = 8,
    parameter bit HAS_CTRL   = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_sel,
    input  logic                  reg_wr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic [NUM_INPUTS-1:0] mode
);
    localparam int PAD_W = REG_W - NUM_INPUTS;
    localparam logic [REG_W-1:0] CAP_VALUE = cap_word(NUM_INPUTS, HAS_CTRL);

    logic [REG_W-1:0] ctrl_view;

    generate
        if (HAS_CTRL) begin : g_ctrl
            logic [NUM_INPUTS-1:0] ctrl_q;
            logic                  unused_wdata;

            // Store the implemented mode bits on a control write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ctrl_q <= '0;
                end else if (reg_wr && (reg_sel == SEL_CTRL)) begin
                    ctrl_q <= reg_wdata[NUM_INPUTS-1:0];
                end
            end

            assign unused_wdata = ^reg_wdata;
            assign mode         = ctrl_q;
            assign ctrl_view    = {{PAD_W{1'b0}}, ctrl_q};
        end else begin : g_no_ctrl
            logic unused_port;

            assign unused_port = ^{reg_wr, reg_wdata, clk, rst_n};
            assign mode        = '0;
            assign ctrl_view   = '0;
        end
    endgenerate

    // Select the register seen on the read port.
    always_comb begin
        if (reg_sel == SEL_CAP) begin
            reg_rdata = CAP_VALUE;
        end else begin
            reg_rdata = ctrl_view;
        end
    end
endmodule

// File: rtl/wp_lane.sv
// Module: sampling conditioner for one watchpoint input.
// Output is registered. Pulse mode gives one cycle per qualifying sample;
// hold mode latches until pre_sample. Setting wins over clearing.
// Assumes the mode value is read only at the sampling edge.
module wp_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic pre,
    input  logic din,
    input  logic mode,
    output logic dout
);
    logic hit;
    logic pulse_q;
    logic hold_q;

    assign hit = strobe & din;

    // Update the pulse and hold state at each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            hold_q  <= 1'b0;
        end else begin
            pulse_q <= hit & ~mode;
            hold_q  <= (hit & mode) | (hold_q & ~pre);
        end
    end

    assign dout = pulse_q | hold_q;
endmodule

// File: rtl/wp_sample_cond.sv
// Module: top of the watchpoint input sampling conditioner.
// Contains the register block and one lane for each fitted input.
// Assumes pre_sample is raised one cycle ahead of each sample_strobe.
module wp_sample_cond
    import wp_pkg::*;
#(
    parameter int NUM_INPUTS = 8,
    parameter bit HAS_CTRL   = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_strobe,
    input  logic                  pre_sample,
    input  logic [NUM_INPUTS-1:0] wp_in,
    output logic [NUM_INPUTS-1:0] wp_out,
    input  logic                  reg_sel,
    input  logic                  reg_wr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata
);
    logic [NUM_INPUTS-1:0] lane_mode;

    wp_ctrl_regs #(
        .NUM_INPUTS(NUM_INPUTS),
        .HAS_CTRL  (HAS_CTRL)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_sel  (reg_sel),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .mode     (lane_mode)
    );

    generate
        for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_lane
            wp_lane u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .strobe(sample_strobe),
                .pre   (pre_sample),
                .din   (wp_in[i]),
                .mode  (lane_mode[i]),
                .dout  (wp_out[i])
            );
        end
    endgenerate
endmodule

// File: rtl/wp_sample_cond_chk.sv
// Module: assertion checker bound to wp_sample_cond.
// Watches the ports and the mode bits that go from the register block to the lanes.
module wp_sample_cond_chk
    import wp_pkg::*;
#(
    parameter int NUM_INPUTS = 8,
    parameter bit HAS_CTRL   = 1'b1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sample_strobe,
    input logic                  pre_sample,
    input logic [NUM_INPUTS-1:0] wp_in,
    input logic [NUM_INPUTS-1:0] wp_out,
    input logic                  reg_sel,
    input logic [REG_W-1:0]      reg_rdata,
    input logic [NUM_INPUTS-1:0] mode
);
    localparam logic [REG_W-1:0] EXP_CAP = cap_word(NUM_INPUTS, HAS_CTRL);

    generate
        for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_lane_chk
            AST_PULSE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
                (sample_strobe && wp_in[i] && !mode[i]) |=> wp_out[i]); // R2
            AST_HOLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
                (sample_strobe && wp_in[i] && mode[i]) |=> wp_out[i]); // R3
            AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (pre_sample && !(sample_strobe && wp_in[i])) |=> !wp_out[i]); // R3
            AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                (pre_sample && sample_strobe && wp_in[i] && mode[i]) |=> wp_out[i]); // R4
            AST_NO_STROBE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
                (!sample_strobe && !wp_out[i]) |=> !wp_out[i]); // R11
        end
    endgenerate

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_CTRL) |-> ((reg_rdata >> NUM_INPUTS) == '0)); // R5
    AST_CAP_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_CAP) |-> (reg_rdata == EXP_CAP)); // R7

    generate
        if (!HAS_CTRL) begin : g_noctrl_chk
            AST_NOCTRL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_sel == SEL_CTRL) |-> (reg_rdata == '0 && mode == '0)); // R8
        end
    endgenerate
endmodule

bind wp_sample_cond wp_sample_cond_chk #(
    .NUM_INPUTS(NUM_INPUTS),
    .HAS_CTRL  (HAS_CTRL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_strobe(sample_strobe),
    .pre_sample   (pre_sample),
    .wp_in        (wp_in),
    .wp_out       (wp_out),
    .reg_sel      (reg_sel),
    .reg_rdata    (reg_rdata),
    .mode         (lane_mode)
);

// File: tb/sim_wp_sample_cond.sv
`timescale 1ns/1ps
// Scoreboard bench: u0 has six inputs and a control word, u1 has eight inputs and none.
module sim_wp_sample_cond;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic        pre = 1'b0;
    logic [7:0]  win = '0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic [5:0]  out0;
    logic [7:0]  out1;

    int checks = 0;
    int errors = 0;
    int cyc_n = 0;

    logic [5:0] m_ctrl = '0;
    logic [5:0] m_hold = '0;

    typedef struct {
        int         due;
        logic [5:0] e0;
        logic [7:0] e1;
        string      tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    wp_sample_cond #(.NUM_INPUTS(6), .HAS_CTRL(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .sample_strobe(strobe), .pre_sample(pre),
        .wp_in(win[5:0]), .wp_out(out0), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(wdata), .reg_rdata(rdata0)
    );

    wp_sample_cond #(.NUM_INPUTS(8), .HAS_CTRL(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .sample_strobe(strobe), .pre_sample(pre),
        .wp_in(win), .wp_out(out1), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(wdata), .reg_rdata(rdata1)
    );

    always @(posedge clk) cyc_n <= cyc_n + 1;

    // Monitor: pops items due in this cycle and compares them with the outputs.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc_n) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (out0 !== it.e0 || out1 !== it.e1) begin
                errors++;
                $display("FAIL %s: out0=%b out1=%b expected out0=%b out1=%b",
                         it.tag, out0, out1, it.e0, it.e1);
            end
        end
    end

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of sampling stimulus; pushes the outputs expected after the edge.
    task automatic step(input logic s, input logic p, input logic [7:0] in, input string tag);
        logic [5:0] hit0, e0;
        @(negedge clk);
        strobe = s; pre = p; win = in; reg_wr = 1'b0; reg_sel = 1'b0;
        hit0   = {6{s}} & in[5:0];
        e0     = hit0 | (m_hold & ~{6{p}});
        m_hold = (hit0 & m_ctrl) | (m_hold & ~{6{p}});
        sb.push_back('{cyc_n + 1, e0, {8{s}} & in, tag});
    endtask

    // Driver: a register write in a quiet cycle; held outputs remain.
    task automatic wr_reg(input logic sel, input logic [31:0] d, input string tag);
        @(negedge clk);
        strobe = 1'b0; pre = 1'b0; win = '0; reg_sel = sel; reg_wr = 1'b1; wdata = d;
        if (sel == 1'b0) m_ctrl = d[5:0];
        sb.push_back('{cyc_n + 1, m_hold, 8'h00, tag});
    endtask

    // Read both instances in a quiet cycle and check the returned words.
    task automatic rd_reg(input logic sel, input logic [31:0] e0, input logic [31:0] e1, input string tag);
        @(negedge clk);
        strobe = 1'b0; pre = 1'b0; win = '0; reg_sel = sel; reg_wr = 1'b0;
        sb.push_back('{cyc_n + 1, m_hold, 8'h00, tag});
        #1;
        check_val({tag, " u0"}, rdata0, e0);
        check_val({tag, " u1"}, rdata1, e1);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R9: state during reset
        check_val("R9 reset out", {18'd0, out1, out0}, 32'd0);
        reg_sel = 1'b0; #1;
        check_val("R9 reset ctrl", rdata0, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R7 capability words; R8 u1 reports no control word
        rd_reg(1'b1, 32'h0000_0016, 32'h0000_0008, "R7 cap");
        wr_reg(1'b1, 32'hFFFF_FFFF, "R7 cap write");
        rd_reg(1'b1, 32'h0000_0016, 32'h0000_0008, "R7 cap after write");

        // R5 R6 R8: all-ones write masks to implemented bits
        wr_reg(1'b0, 32'hFFFF_FFFF, "R5 write ones");
        rd_reg(1'b0, 32'h0000_003F, 32'h0, "R5 R6 R8 readback");

        // R2 pulse mode, input held high between strobes (R11)
        wr_reg(1'b0, 32'h0, "R1 clear modes");
        step(1'b1, 1'b0, 8'hFF, "R2 pulse sample");
        step(1'b0, 1'b0, 8'hFF, "R2 pulse ends");
        step(1'b0, 1'b0, 8'hFF, "R11 no strobe");
        step(1'b1, 1'b0, 8'h00, "R11 inactive at strobe");
        step(1'b0, 1'b0, 8'hA5, "R11 idle");

        // R1 R3 hold mode on bits 0 and 2; R8 u1 keeps pulsing
        wr_reg(1'b0, 32'h0000_0005, "R1 set hold 0,2");
        step(1'b1, 1'b0, 8'h0F, "R3 hold sample");
        step(1'b0, 1'b0, 8'h00, "R3 held 1");
        step(1'b0, 1'b0, 8'h00, "R3 held 2");
        step(1'b0, 1'b1, 8'h00, "R3 pre clears");
        step(1'b1, 1'b0, 8'h00, "R3 cleared at strobe");
        step(1'b0, 1'b0, 8'h00, "R3 idle");

        // R4 back-to-back: pre_sample coincides with a qualifying strobe
        step(1'b1, 1'b0, 8'h01, "R4 first sample");
        step(1'b1, 1'b1, 8'h01, "R4 overlap");
        step(1'b0, 1'b1, 8'h00, "R4 final clear");
        step(1'b0, 1'b0, 8'h00, "R4 idle");

        // R10 mode cleared while held: output survives until pre_sample
        step(1'b1, 1'b0, 8'h04, "R10 hold input 2");
        wr_reg(1'b0, 32'h0, "R10 write during hold");
        step(1'b0, 1'b0, 8'h00, "R10 still held");
        step(1'b0, 1'b1, 8'h00, "R10 pre clears");
        step(1'b1, 1'b0, 8'h04, "R10 now pulse");
        step(1'b0, 1'b0, 8'h04, "R10 pulse ends");

        // R9 mid-run reset with a held output
        wr_reg(1'b0, 32'h0000_0020, "R1 hold bit 5");
        step(1'b1, 1'b0, 8'h20, "R1 hold 5 sample");
        step(1'b0, 1'b0, 8'h00, "R1 hold 5 held");
        @(negedge clk);
        strobe = 1'b0; pre = 1'b0; win = '0; reg_sel = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        m_hold = '0; m_ctrl = '0;
        #1;
        check_val("R9 mid reset out", {18'd0, out1, out0}, 32'd0);
        check_val("R9 mid reset ctrl", rdata0, 32'd0);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 8'h20, "R9 pulse after reset");
        step(1'b0, 1'b0, 8'h00, "R9 pulse after reset ends");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule